// File: doc/BRIEF.md
# Shared-Adder Arithmetic Logic Unit

This block is the execute-stage arithmetic logic unit of a small pipelined processor. It is purely combinational. It takes two 32-bit two's-complement operands and a 16-bit immediate. A select input decides whether the second operand is the register value or the extended immediate. A 4-bit operation code picks one of eleven functions. The block drives a 32-bit result, a carry-out flag and a zero flag in the same cycle.

Addition, subtraction and both less-than comparisons share one adder. Subtraction is built as A plus the inverted second operand plus one. The two comparisons come from the operand sign bits and the sign bit of that difference. The immediate is sign-extended for the arithmetic and compare functions. It is zero-extended for the bitwise functions. A barrel shifter with log2(32) stages serves all three shift kinds.

Top module: `alu32`

## Requirements
- R1: Operation code 0 (add) gives result = low 32 bits of A + second operand, and carry = bit 32 of that sum.
- R2: Operation code 1 (subtract) gives result = A + ~second + 1 (mod 2^32). Carry is bit 32 of that sum, which is 1 exactly when A >= second as unsigned values.
- R3: Operation code 2 (signed less-than) gives result 1 when A < second as signed values, else 0. Carry is 0.
- R4: Operation code 3 (unsigned less-than) gives result 1 when A < second as unsigned values, else 0. Carry is 0.
- R5: Operation codes 4, 5, 6 and 7 give bitwise AND, OR, XOR and NOR of A and the second operand, with carry 0.
- R6: When use_imm_i is 1, the second operand is the immediate instead of B. It is sign-extended (bit 15 copied upward) for codes 0 to 3, and zero-extended for codes 4 to 7.
- R7: Operation codes 8 (shift left) and 9 (logical shift right) shift A by the low 5 bits of the second operand and fill with zeros. An amount of 0 returns A. Carry is 0.
- R8: Operation code 10 (arithmetic shift right) shifts A right by the low 5 bits of the second operand and fills the vacated bits with A[31]. Carry is 0.
- R9: zero_o is 1 exactly when the 32-bit result is zero, for every operation code.
- R10: Operation codes 11 to 15 drive result 0 and carry 0, and therefore zero_o = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Register second operand |
| imm_i | input | 16 | Immediate field |
| use_imm_i | input | 1 | 1 selects the extended immediate as second operand |
| result_o | output | 32 | Operation result |
| carry_o | output | 1 | Adder carry-out for add and subtract, else 0 |
| zero_o | output | 1 | Result equals zero |

## Verification
Operands that differ in sign get special attention. The most negative value against the most positive value, and -1 against 0, show whether each comparison uses the right rule. A design that takes the signed rule for the unsigned test, or reads only the difference sign, returns the inverted answer for exactly these pairs. Immediates with bit 15 set separate sign extension from zero extension: a wrong extension flips the upper half of an AND or an ADD result. Shift amounts of 0, 31 and values above 31 in the second operand show whether the masking and the fill are right. An arithmetic shift that fills with zeros gives a positive result from a negative input. Subtractions that borrow and that do not borrow show whether the carry is inverted, and unknown codes show any stale result leaking out.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_SLT  = 4'd2,
    OP_SLTU = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_NOR  = 4'd7,
    OP_SLL  = 4'd8,
    OP_SRL  = 4'd9,
    OP_SRA  = 4'd10
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'd0,
    SH_RLOG  = 2'd1,
    SH_RARI  = 2'd2
  } shift_kind_e;

  // Arithmetic and compare codes take a sign-extended immediate.
  function automatic logic imm_signed(input logic [3:0] op);
    return (op <= 4'd3);
  endfunction

  // Codes that route through the shared adder in subtract form.
  function automatic logic uses_subtract(input logic [3:0] op);
    return (op == OP_SUB) || (op == OP_SLT) || (op == OP_SLTU);
  endfunction

endpackage

// File: rtl/alu_operand_sel.sv
module alu_operand_sel #(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16
) (
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             use_imm_i,
  output logic [WIDTH-1:0] opnd_o
);
  import alu_pkg::*;

  localparam int EXT_W = WIDTH - IMM_W;

  logic             ext_bit;
  logic [WIDTH-1:0] imm_ext;

  // Fill value: immediate sign bit for arithmetic forms, zero for logical.
  assign ext_bit = imm_signed(op_i) & imm_i[IMM_W-1];
  assign imm_ext = {{EXT_W{ext_bit}}, imm_i};
  assign opnd_o  = use_imm_i ? imm_ext : b_i;

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             lt_s_o,
  output logic             lt_u_o
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   full;
  logic             same_msb;

  // One adder: subtraction adds the inverted operand plus a carry-in of one.
  assign b_eff    = sub_i ? ~b_i : b_i;
  assign full     = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_i};
  assign sum_o    = full[WIDTH-1:0];
  assign cout_o   = full[WIDTH];

  // Comparisons: differing top bits decide directly, otherwise the
  // difference sign decides (no overflow is possible in that case).
  assign same_msb = ~(a_i[MSB] ^ b_i[MSB]);
  assign lt_s_o   = (a_i[MSB] & ~b_i[MSB]) | (same_msb & full[MSB]);
  assign lt_u_o   = (~a_i[MSB] & b_i[MSB]) | (same_msb & full[MSB]);

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0]         a_i,
  input  logic [$clog2(WIDTH)-1:0] amt_i,
  input  alu_pkg::shift_kind_e     kind_i,
  output logic [WIDTH-1:0]         out_o
);
  import alu_pkg::*;

  localparam int STAGES = $clog2(WIDTH);

  logic             go_left;
  logic             fill;
  logic [WIDTH-1:0] src;
  logic [WIDTH-1:0] stg [0:STAGES];

  assign go_left = (kind_i == SH_LEFT);
  assign fill    = (kind_i == SH_RARI) & a_i[WIDTH-1];

  // Left shifts reuse the right-shift network on a bit-reversed operand.
  always_comb begin
    for (int i = 0; i < WIDTH; i++) begin
      src[i] = go_left ? a_i[WIDTH-1-i] : a_i[i];
    end
  end

  assign stg[0] = src;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    localparam int D = 1 << s;
    assign stg[s+1] = amt_i[s] ? {{D{fill}}, stg[s][WIDTH-1:D]} : stg[s];
  end

  always_comb begin
    for (int i = 0; i < WIDTH; i++) begin
      out_o[i] = go_left ? stg[STAGES][WIDTH-1-i] : stg[STAGES][i];
    end
  end

endmodule

// File: rtl/alu32.sv
module alu32 #(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16
) (
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             use_imm_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o,
  output logic             zero_o
);
  import alu_pkg::*;

  localparam int SHAMT_W = $clog2(WIDTH);

  logic [WIDTH-1:0] opnd;
  logic [WIDTH-1:0] sum;
  logic             cout;
  logic             lt_s;
  logic             lt_u;
  logic [WIDTH-1:0] shifted;
  shift_kind_e      sh_kind;
  logic             do_sub;

  alu_operand_sel #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_opsel (
    .op_i      (op_i),
    .b_i       (b_i),
    .imm_i     (imm_i),
    .use_imm_i (use_imm_i),
    .opnd_o    (opnd)
  );

  assign do_sub = uses_subtract(op_i);

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a_i    (a_i),
    .b_i    (opnd),
    .sub_i  (do_sub),
    .sum_o  (sum),
    .cout_o (cout),
    .lt_s_o (lt_s),
    .lt_u_o (lt_u)
  );

  always_comb begin
    unique case (op_i)
      OP_SRL:  sh_kind = SH_RLOG;
      OP_SRA:  sh_kind = SH_RARI;
      default: sh_kind = SH_LEFT;
    endcase
  end

  alu_shifter #(.WIDTH(WIDTH)) u_shift (
    .a_i    (a_i),
    .amt_i  (opnd[SHAMT_W-1:0]),
    .kind_i (sh_kind),
    .out_o  (shifted)
  );

  always_comb begin
    result_o = '0;
    carry_o  = 1'b0;
    case (op_i)
      OP_ADD, OP_SUB: begin
        result_o = sum;
        carry_o  = cout;
      end
      OP_SLT:  result_o = {{(WIDTH-1){1'b0}}, lt_s};
      OP_SLTU: result_o = {{(WIDTH-1){1'b0}}, lt_u};
      OP_AND:  result_o = a_i & opnd;
      OP_OR:   result_o = a_i | opnd;
      OP_XOR:  result_o = a_i ^ opnd;
      OP_NOR:  result_o = ~(a_i | opnd);
      OP_SLL, OP_SRL, OP_SRA: result_o = shifted;
      default: begin
        result_o = '0;
        carry_o  = 1'b0;
      end
    endcase
  end

  assign zero_o = (result_o == '0);

endmodule

// File: rtl/alu32_checker.sv
module alu32_checker #(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16
) (
  input logic [3:0]       op_i,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [IMM_W-1:0] imm_i,
  input logic             use_imm_i,
  input logic [WIDTH-1:0] result_o,
  input logic             carry_o,
  input logic             zero_o
);

  localparam int SHAMT_W = $clog2(WIDTH);

  logic [SHAMT_W-1:0] amt;
  assign amt = use_imm_i ? imm_i[SHAMT_W-1:0] : b_i[SHAMT_W-1:0];

  always_comb begin
    AST_CMP_BOOLEAN: assert (!((op_i == 4'd2) || (op_i == 4'd3)) || (result_o[WIDTH-1:1] == '0)); // R3
    AST_ULT_EQUAL_FALSE: assert (!((op_i == 4'd3) && !use_imm_i && (a_i == b_i)) || (result_o == '0)); // R4
    AST_LOGIC_NO_CARRY: assert (!((op_i >= 4'd4) && (op_i <= 4'd10)) || !carry_o); // R5
    AST_ANDI_UPPER_CLEAR: assert (!((op_i == 4'd4) && use_imm_i) || (result_o[WIDTH-1:IMM_W] == '0)); // R6
    AST_SHIFT_ZERO_PASS: assert (!((op_i >= 4'd8) && (op_i <= 4'd10) && (amt == '0)) || (result_o == a_i)); // R7
    AST_SRA_KEEPS_SIGN: assert (!((op_i == 4'd10) && a_i[WIDTH-1]) || result_o[WIDTH-1]); // R8
    AST_BAD_OP_QUIET: assert (!(op_i >= 4'd11) || (zero_o && !carry_o)); // R10
  end

endmodule

bind alu32 alu32_checker #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_alu32_chk (
  .op_i      (op_i),
  .a_i       (a_i),
  .b_i       (b_i),
  .imm_i     (imm_i),
  .use_imm_i (use_imm_i),
  .result_o  (result_o),
  .carry_o   (carry_o),
  .zero_o    (zero_o)
);

// File: tb/alu32_bench.sv
module alu32_bench;

  typedef struct {
    logic [3:0]  op;
    logic [31:0] a;
    logic [31:0] opnd;
    logic        imm;
    logic [31:0] res;
    logic        cy;
    logic        zf;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic [3:0]  op_i;
  logic [31:0] a_i;
  logic [31:0] b_i;
  logic [15:0] imm_i;
  logic        use_imm_i;
  logic [31:0] result_o;
  logic        carry_o;
  logic        zero_o;

  int   n_vec;
  int   n_bad;
  bit   done;
  exp_t sb_q[$];

  alu32 u_alu32 (
    .op_i      (op_i),
    .a_i       (a_i),
    .b_i       (b_i),
    .imm_i     (imm_i),
    .use_imm_i (use_imm_i),
    .result_o  (result_o),
    .carry_o   (carry_o),
    .zero_o    (zero_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic string req_of(input logic [3:0] op, input logic imm);
    if (imm && op <= 4'd7) return "R6";
    case (op)
      4'd0:                      return "R1";
      4'd1:                      return "R2";
      4'd2:                      return "R3";
      4'd3:                      return "R4";
      4'd4, 4'd5, 4'd6, 4'd7:    return "R5";
      4'd8, 4'd9:                return "R7";
      4'd10:                     return "R8";
      default:                   return "R10";
    endcase
  endfunction

  task automatic apply(input logic [3:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] imm,
                       input logic use_imm);
    exp_t        e;
    logic [31:0] o;
    logic [32:0] wide;
    int          sh;
    @(posedge clk);
    #1;
    op_i = op; a_i = a; b_i = b; imm_i = imm; use_imm_i = use_imm;
    if (!use_imm)        o = b;
    else if (op <= 4'd3) o = 32'($signed(imm));
    else                 o = {16'h0000, imm};
    sh = int'(o[4:0]);
    e.cy = 1'b0;
    case (op)
      4'd0: begin wide = {1'b0, a} + {1'b0, o}; e.res = wide[31:0]; e.cy = wide[32]; end
      4'd1: begin e.res = a - o; e.cy = (a >= o); end
      4'd2: e.res = ($signed(a) < $signed(o)) ? 32'd1 : 32'd0;
      4'd3: e.res = (a < o) ? 32'd1 : 32'd0;
      4'd4: e.res = a & o;
      4'd5: e.res = a | o;
      4'd6: e.res = a ^ o;
      4'd7: e.res = ~(a | o);
      4'd8: e.res = a << sh;
      4'd9: e.res = a >> sh;
      4'd10: e.res = 32'($signed(a) >>> sh);
      default: e.res = 32'd0;
    endcase
    e.zf = (e.res == 32'd0);
    e.op = op; e.a = a; e.opnd = o; e.imm = use_imm;
    sb_q.push_back(e);
  endtask

  // Monitor: compares between edges, after the inputs have settled.
  always @(negedge clk) begin
    if (rst_n && sb_q.size() > 0) begin
      exp_t e;
      bit   bad;
      e = sb_q.pop_front();
      bad = 1'b0;
      n_vec++;
      if (result_o !== e.res) begin
        bad = 1'b1;
        $display("FAIL %s result op=%0d a=%h opnd=%h actual=%h expected=%h",
                 req_of(e.op, e.imm), e.op, e.a, e.opnd, result_o, e.res);
      end
      if (carry_o !== e.cy) begin
        bad = 1'b1;
        $display("FAIL %s carry op=%0d a=%h opnd=%h actual=%b expected=%b",
                 req_of(e.op, e.imm), e.op, e.a, e.opnd, carry_o, e.cy);
      end
      if (zero_o !== e.zf) begin
        bad = 1'b1;
        $display("FAIL R9 zero op=%0d a=%h opnd=%h actual=%b expected=%b",
                 e.op, e.a, e.opnd, zero_o, e.zf);
      end
      if (bad) n_bad++;
    end
  end

  initial begin
    logic [31:0] corner [6];
    corner[0] = 32'h0000_0000; corner[1] = 32'hFFFF_FFFF;
    corner[2] = 32'h8000_0000; corner[3] = 32'h7FFF_FFFF;
    corner[4] = 32'h0000_0001; corner[5] = 32'h0000_0023;
    n_vec = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0;
    op_i = 4'd0; a_i = '0; b_i = '0; imm_i = '0; use_imm_i = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Idle inputs with an unknown code: quiet outputs (R10).
    apply(4'd15, 32'h0, 32'h0, 16'h0, 1'b0);
    // Corner pairs for every code, register operand (R1..R5, R7, R8, R9).
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          apply(4'(op), corner[i], corner[j], 16'h0, 1'b0);
    // Shift amounts 0, 31 and values above 31 (R7, R8).
    for (int op = 8; op <= 10; op++)
      for (int s = 0; s < 40; s++)
        apply(4'(op), 32'hA5C3_0F81, 32'(s), 16'h0, 1'b0);
    // Immediate forms with bit 15 set and clear (R6).
    for (int op = 0; op <= 10; op++) begin
      apply(4'(op), 32'hFFFF_0001, 32'hDEAD_BEEF, 16'h8001, 1'b1);
      apply(4'(op), 32'h1234_5678, 32'hDEAD_BEEF, 16'h7FFF, 1'b1);
      apply(4'(op), 32'h8000_0000, 32'h0, 16'hFFFF, 1'b1);
      apply(4'(op), 32'h0000_0000, 32'h0, 16'h0000, 1'b1);
    end
    // Subtraction with and without borrow (R2).
    apply(4'd1, 32'd5, 32'd5, 16'h0, 1'b0);
    apply(4'd1, 32'd4, 32'd5, 16'h0, 1'b0);
    // Random operands across all codes and both operand sources.
    for (int k = 0; k < 3000; k++)
      apply(4'($urandom_range(0, 15)), $urandom, $urandom,
            16'($urandom), 1'($urandom_range(0, 1)));
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule